// File: doc/BRIEF.md
# Instruction-Encoded Integer ALU Card

This block is the combinational arithmetic and logic card of a 32-bit integer datapath. It takes two operands and a 4-bit operation code. The code is taken straight from the instruction word, with no decode step: the three function bits sit in bits 2:0, and bit 5 of the seven-bit function field sits in bit 3. The card computes add, subtract, signed and unsigned set-less-than, XOR, OR and AND. It places the result on a shared result bus within the same cycle.

The card shares the result bus with a separate shifter card. Only 10 of the 16 code values mean anything, and none of them is kept aside to mean "no output". A single bus enable therefore decides whether either card drives the bus at all. When the enable is high, the code value decides which card drives. This card drives only for its own seven codes. For shift codes, undefined codes, or a low enable, it releases the bus. Released means the result port reads zero and the drive flag is low, so the bus can be formed by ORing the cards' outputs.

Top module: `alu_card`

## Requirements
- R1: With the bus enable high and code 4'b0000, the result is opA + opB modulo 2^32, and the drive flag is high.
- R2: With the bus enable high and code 4'b1000, the result is opA - opB modulo 2^32, and the drive flag is high.
- R3: With the bus enable high and code 4'b0010, the result is 1 when opA < opB as two's-complement numbers, and 0 otherwise, zero-extended to 32 bits. This holds where the subtraction overflows, for example 0x80000000 compared with a positive value.
- R4: With the bus enable high and code 4'b0011, the result is 1 when opA < opB as unsigned numbers, and 0 otherwise, zero-extended to 32 bits.
- R5: With the bus enable high, code 4'b0100 gives opA XOR opB, code 4'b0110 gives opA OR opB, and code 4'b0111 gives opA AND opB.
- R6: For the shift codes 4'b0001, 4'b0101 and 4'b1101, the card releases the bus: the result is all zeros and the drive flag is low, whatever the operands and the enable.
- R7: For the undefined codes 4'b1001, 4'b1010, 4'b1011, 4'b1100, 4'b1110 and 4'b1111, the card releases the bus: the result is zero and the drive flag is low.
- R8: With the bus enable low, the card releases the bus for every code and every pair of operands.
- R9: The drive flag is high exactly when the enable is high and the code is one of the seven codes in R1 to R5. Whenever the drive flag is low, the result is zero. The output follows the inputs in the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| opCode | input | 4 | {function-field bit 5, function field[2:0]} |
| busEn | input | 1 | Result-bus enable shared with the shifter card |
| busOut | output | 32 | Result toward the shared bus, zero when released |
| busDrive | output | 1 | High while this card owns the bus |

## Verification
The card holds no state, so any fault shows at the ports in the same cycle as the inputs that trigger it. A wrong control strobe shows in one of three ways. A code routed to the wrong unit gives a wrong value. A missing release gives a non-zero result or a high drive flag next to the shifter's codes. A bad comparison gives a wrong set-less-than bit, which boundary operands near the sign bit expose. Every one of the 16 codes is crossed with both enable levels, boundary pairs and random pairs, and the result is compared with a behavioural model on each clock.

// File: rtl/alu_card_pkg.sv
package alu_card_pkg;

  typedef enum logic [3:0] {
    CodeAdd  = 4'b0000,
    CodeSll  = 4'b0001,
    CodeSlt  = 4'b0010,
    CodeSltu = 4'b0011,
    CodeXor  = 4'b0100,
    CodeSrl  = 4'b0101,
    CodeOr   = 4'b0110,
    CodeAnd  = 4'b0111,
    CodeSub  = 4'b1000,
    CodeSra  = 4'b1101
  } aluCode_e;

  typedef struct packed {
    logic drive;
    logic invB;
    logic pickSum;
    logic pickLess;
    logic lessSigned;
    logic pickXor;
    logic pickOr;
    logic pickAnd;
  } aluStrobe_t;

endpackage

// File: rtl/alu_card_ctrl.sv
module alu_card_ctrl
  import alu_card_pkg::*;
(
  input  logic [3:0]  opCode,
  input  logic        busEn,
  output aluStrobe_t  strobe
);

  aluStrobe_t raw;

  always_comb begin
    raw = '0;
    case (opCode)
      CodeAdd:  begin raw.drive = 1'b1; raw.pickSum = 1'b1; end
      CodeSub:  begin raw.drive = 1'b1; raw.pickSum = 1'b1; raw.invB = 1'b1; end
      CodeSlt:  begin raw.drive = 1'b1; raw.pickLess = 1'b1; raw.invB = 1'b1;
                      raw.lessSigned = 1'b1; end
      CodeSltu: begin raw.drive = 1'b1; raw.pickLess = 1'b1; raw.invB = 1'b1; end
      CodeXor:  begin raw.drive = 1'b1; raw.pickXor = 1'b1; end
      CodeOr:   begin raw.drive = 1'b1; raw.pickOr = 1'b1; end
      CodeAnd:  begin raw.drive = 1'b1; raw.pickAnd = 1'b1; end
      default:  raw = '0;
    endcase
  end

  // A low enable silences every select, not just the drive flag.
  assign strobe = busEn ? raw : '0;

endmodule

// File: rtl/alu_card_dp.sv
module alu_card_dp
  import alu_card_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluStrobe_t       strobe,
  output logic [WIDTH-1:0] result,
  output logic             driving
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] bEff;
  logic [WIDTH-1:0] sum;
  logic             carryOut;
  logic             overflow;
  logic             lessBit;
  logic [WIDTH-1:0] lessWord;
  logic [WIDTH-1:0] logicWord;

  assign bEff = opB ^ {WIDTH{strobe.invB}};
  assign {carryOut, sum} = {1'b0, opA} + {1'b0, bEff} + {{WIDTH{1'b0}}, strobe.invB};

  // Signed overflow: same-sign inputs produce a sum of the other sign.
  assign overflow = (opA[MSB] == bEff[MSB]) && (sum[MSB] != opA[MSB]);
  assign lessBit  = strobe.lessSigned ? (sum[MSB] ^ overflow) : ~carryOut;
  assign lessWord = {{(WIDTH-1){1'b0}}, lessBit};

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign logicWord[i] = (strobe.pickXor & (opA[i] ^ opB[i]))
                        | (strobe.pickOr  & (opA[i] | opB[i]))
                        | (strobe.pickAnd & (opA[i] & opB[i]));
  end

  always_comb begin
    result = logicWord;
    if (strobe.pickSum)  result = result | sum;
    if (strobe.pickLess) result = result | lessWord;
    if (!strobe.drive)   result = '0;
  end

  assign driving = strobe.drive;

endmodule

// File: rtl/alu_card.sv
module alu_card
  import alu_card_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [3:0]       opCode,
  input  logic             busEn,
  output logic [WIDTH-1:0] busOut,
  output logic             busDrive
);

  aluStrobe_t strobe;

  alu_card_ctrl u_ctrl (
    .opCode (opCode),
    .busEn  (busEn),
    .strobe (strobe)
  );

  alu_card_dp #(.WIDTH(WIDTH)) u_dp (
    .opA     (opA),
    .opB     (opB),
    .strobe  (strobe),
    .result  (busOut),
    .driving (busDrive)
  );

endmodule

// File: rtl/alu_card_chk.sv
module alu_card_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [3:0]       opCode,
  input logic             busEn,
  input logic [WIDTH-1:0] busOut,
  input logic             busDrive
);

  logic isShift;
  logic isLess;
  assign isShift = (opCode == 4'b0001) || (opCode == 4'b0101) || (opCode == 4'b1101);
  assign isLess  = (opCode == 4'b0010) || (opCode == 4'b0011);

  always_comb begin
    assert_release_R8: assert (busEn || (!busDrive && busOut == '0))
      else $error("enable low but card drives");
    assert_quiet_R9: assert (busDrive || busOut == '0)
      else $error("released card shows non-zero result");
    assert_shift_off_R6: assert (!(isShift && busDrive))
      else $error("card drives on a shift code");
    assert_less_width_R3: assert (!(busDrive && isLess) || busOut[WIDTH-1:1] == '0)
      else $error("set-less-than not zero-extended");
    assert_add_R1: assert (!(busDrive && opCode == 4'b0000) || busOut == opA + opB)
      else $error("add result wrong");
    assert_xor_R5: assert (!(busDrive && opCode == 4'b0100) || busOut == (opA ^ opB))
      else $error("xor result wrong");
  end

endmodule

bind alu_card alu_card_chk #(.WIDTH(WIDTH)) u_chk (
  .opA      (opA),
  .opB      (opB),
  .opCode   (opCode),
  .busEn    (busEn),
  .busOut   (busOut),
  .busDrive (busDrive)
);

// File: tb/sim_alu_card.sv
module sim_alu_card;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [3:0]  opCode = '0;
  logic        busEn = 1'b0;
  logic [31:0] busOut;
  logic        busDrive;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_card u0 (
    .opA(opA), .opB(opB), .opCode(opCode), .busEn(busEn),
    .busOut(busOut), .busDrive(busDrive)
  );

  // Behavioural reference of the card.
  function automatic logic [32:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [3:0] c, input logic en);
    logic [31:0] r;
    logic        d;
    d = 1'b1;
    case (c)
      4'b0000: r = a + b;
      4'b1000: r = a - b;
      4'b0010: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      4'b0011: r = (a < b) ? 32'd1 : 32'd0;
      4'b0100: r = a ^ b;
      4'b0110: r = a | b;
      4'b0111: r = a & b;
      default: begin r = '0; d = 1'b0; end
    endcase
    if (!en) begin r = '0; d = 1'b0; end
    return {d, r};
  endfunction

  function automatic string reqOf(input logic [3:0] c, input logic en);
    if (!en) return "R8";
    case (c)
      4'b0000: return "R1";
      4'b1000: return "R2";
      4'b0010: return "R3";
      4'b0011: return "R4";
      4'b0100, 4'b0110, 4'b0111: return "R5";
      4'b0001, 4'b0101, 4'b1101: return "R6";
      default: return "R7";
    endcase
  endfunction

  // Apply inputs after a rising edge, compare at the following falling edge.
  task automatic applyAndCheck(input logic [31:0] a, input logic [31:0] b,
                               input logic [3:0] c, input logic en);
    logic [32:0] exp;
    @(posedge clk);
    opA = a; opB = b; opCode = c; busEn = en;
    @(negedge clk);
    exp = model(a, b, c, en);
    total++;
    if (busOut !== exp[31:0] || busDrive !== exp[32]) begin
      bad++;
      $display("FAIL %s (R9 drive) code=%b en=%b a=%h b=%h actual=%h/%b expected=%h/%b",
               reqOf(c, en), c, en, a, b, busOut, busDrive, exp[31:0], exp[32]);
    end
  endtask

  logic [31:0] edgeA [9];
  logic [31:0] edgeB [9];

  initial begin
    edgeA[0] = 32'h0000_0000; edgeB[0] = 32'h0000_0000;
    edgeA[1] = 32'h8000_0000; edgeB[1] = 32'h0000_0001;
    edgeA[2] = 32'h8000_0000; edgeB[2] = 32'h7fff_ffff;
    edgeA[3] = 32'h7fff_ffff; edgeB[3] = 32'h8000_0000;
    edgeA[4] = 32'hffff_ffff; edgeB[4] = 32'h0000_0000;
    edgeA[5] = 32'h0000_0000; edgeB[5] = 32'hffff_ffff;
    edgeA[6] = 32'hffff_ffff; edgeB[6] = 32'hffff_ffff;
    edgeA[7] = 32'h0000_0001; edgeB[7] = 32'hffff_ffff;
    edgeA[8] = 32'h1234_5678; edgeB[8] = 32'h1234_5678;

    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    total++;  // R8: reset state with enable low
    if (busOut !== 32'd0 || busDrive !== 1'b0) begin
      bad++;
      $display("FAIL R8 reset state actual=%h/%b expected=0/0", busOut, busDrive);
    end

    for (int en = 1; en >= 0; en--) begin
      for (int c = 0; c < 16; c++) begin
        for (int k = 0; k < 9; k++)
          applyAndCheck(edgeA[k], edgeB[k], 4'(c), 1'(en));
        for (int k = 0; k < 40; k++)
          applyAndCheck($urandom, $urandom, 4'(c), 1'(en));
      end
    end

    // R3 overflow corner, written out
    applyAndCheck(32'h8000_0000, 32'h0000_0005, 4'b0010, 1'b1);
    applyAndCheck(32'h0000_0005, 32'h8000_0000, 4'b0010, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule